// File: doc/BRIEF.md
# SDRAM Command Bus Monitor with Per-Bank Row Tracking

This block listens to the registered control and address lines of a four-bank SDRAM on every rising clock edge. It turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into one decoded command code. From that code it keeps a record of which banks hold an open row and which row each one holds. Commands that break the bank protocol raise a violation code for one cycle.

It follows the address-bit-10 qualifier in both of its roles. On a precharge, that bit selects every bank instead of one. On a read or write, it arms a self-timed close of the bank once the burst ends. The monitor learns the burst length by keeping a copy of the mode register word from the last load that was legal. It also tracks self refresh: the state is entered by a refresh command given with the clock enable low, and while it lasts every command is ignored.

All outputs are registered. A command sampled at edge n appears on the outputs right after edge n. A bank closed by auto-precharge after a burst of length L shows as closed right after edge n+L.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Output `cmd_o` codes the command seen at each edge. With chip select high it is 0 (inhibit). With chip select low, the row/column/write strobe levels map as follows: HHH gives 1 (no-op), LHH gives 2 (activate), HLH gives 3 (read), HLL gives 4 (write), HHL gives 5 (burst stop), LHL gives 6 (precharge), LLH gives 7 (auto refresh) when the clock enable is high or 8 (self refresh) when it is low, and LLL gives 9 (mode load).
- R2: An activate to an idle bank opens that bank (bit `ba` of `bank_open_o`) and stores `addr` as its row in slice `ba` of `open_row_o`.
- R3: An activate to a bank that is already open gives violation code 1. The bank keeps its stored row.
- R4: A read or write to an idle bank gives violation code 2 and changes no bank state.
- R5: A read or write to an open bank with `addr[10]` high sets that bank's bit in `ap_pend_o`. For a burst of length L, it closes the bank so that the bank reads as idle after edge n+L. The mode field `addr[2:0]` selects the length: 000 gives 1, 001 gives 2, 010 gives 4, and 011 gives 8.
- R6: With length code 111 (full page), `addr[10]` on a read or write arms nothing, and the bank stays open.
- R7: With mode bit 9 set, a write with auto-precharge closes its bank after one cycle. Reads still use the programmed length.
- R8: A precharge with `addr[10]` high closes all banks. With `addr[10]` low it closes only bank `ba`.
- R9: A mode load while every bank is idle is stored. A mode load while any bank is open gives violation code 3 and is not stored.
- R10: A refresh (auto or self) while any bank is open gives violation code 4.
- R11: A self refresh sets `self_ref_o`. While it is set, every command is ignored and reported as 0. The first edge with the clock enable high clears the state, and that edge's command is also ignored.
- R12: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable level |
| addr | input | ROW_W (13) | Address lines |
| ba | input | BA_W (2) | Bank select |
| cmd_o | output | 4 | Decoded command code |
| viol_o | output | 1 | Violation seen at last edge |
| viol_code_o | output | 3 | Violation kind, 0 when none |
| bank_open_o | output | NBANK (4) | One bit per open bank |
| open_row_o | output | NBANK*ROW_W (52) | Stored row per bank, bank 0 in low bits |
| ap_pend_o | output | NBANK (4) | Auto-precharge armed per bank |
| self_ref_o | output | 1 | Self refresh in progress |

## Verification
The hardest case to reach is a mode load refused because a bank is busy. The refusal can only be seen indirectly, through the close time of a later auto-precharge burst. The stimulus first loads a length of eight and opens two banks. It then attempts a load of length two, which must be refused. Finally it issues an auto-precharge read and counts NOP cycles until the bank closes at edge n+8, not n+2. Self-refresh exit is reached by a refresh with the clock enable low, followed by an activate that must be ignored, and then a release cycle.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

    localparam int CNT_W       = 4;
    localparam int WSINGLE_BIT = 9;
    localparam logic [2:0] FULL_PAGE_CODE = 3'b111;

    typedef enum logic [3:0] {
        C_INHIBIT = 4'd0,
        C_NOP     = 4'd1,
        C_ACT     = 4'd2,
        C_READ    = 4'd3,
        C_WRITE   = 4'd4,
        C_BTERM   = 4'd5,
        C_PRE     = 4'd6,
        C_AREF    = 4'd7,
        C_SREF    = 4'd8,
        C_LMODE   = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_ACT_OPEN  = 3'd1,
        V_IDLE_ACC  = 3'd2,
        V_MODE_BUSY = 3'd3,
        V_REF_BUSY  = 3'd4
    } viol_e;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic cke);
        cmd_e r;
        if (cs_n) begin
            r = C_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  r = C_NOP;
                3'b011:  r = C_ACT;
                3'b101:  r = C_READ;
                3'b100:  r = C_WRITE;
                3'b110:  r = C_BTERM;
                3'b010:  r = C_PRE;
                3'b001:  r = cke ? C_AREF : C_SREF;
                default: r = C_LMODE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] burst_len(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'b001:  r = CNT_W'(2);
            3'b010:  r = CNT_W'(4);
            3'b011:  r = CNT_W'(8);
            default: r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
    import sdmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic self_ref,
    output cmd_e op
);
    always_comb begin
        if (self_ref) op = C_INHIBIT;
        else          op = decode_cmd(cs_n, ras_n, cas_n, we_n, cke);
    end
endmodule

// File: rtl/sdmon_mode.sv
module sdmon_mode
    import sdmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [2:0]       bl_code_in,
    input  logic             wr_single_in,
    output logic [CNT_W-1:0] bl,
    output logic             full_page,
    output logic             wr_single
);
    logic [2:0] code_q;
    logic       ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 3'b000;
            ws_q   <= 1'b0;
        end else if (load) begin
            code_q <= bl_code_in;
            ws_q   <= wr_single_in;
        end
    end

    assign bl        = burst_len(code_q);
    assign full_page = (code_q == FULL_PAGE_CODE);
    assign wr_single = ws_q;
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_hit,
    input  logic             close_hit,
    input  logic             ap_start,
    input  logic [CNT_W-1:0] ap_len,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             pend_o
);
    logic             open_q;
    logic             pend_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
            row_q  <= '0;
            cnt_q  <= '0;
        end else if (close_hit) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (act_hit) begin
                open_q <= 1'b1;
                row_q  <= row_in;
            end
            if (ap_start) begin
                pend_q <= 1'b1;
                cnt_q  <= ap_len;
            end else if (pend_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    pend_q <= 1'b0;
                    open_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign open_o = open_q;
    assign row_o  = row_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sdmon_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [ROW_W-1:0]       addr,
    input  logic [BA_W-1:0]        ba,
    output logic [3:0]             cmd_o,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o,
    output logic [NBANK-1:0]       bank_open_o,
    output logic [NBANK*ROW_W-1:0] open_row_o,
    output logic [NBANK-1:0]       ap_pend_o,
    output logic                   self_ref_o
);
    cmd_e             op;
    viol_e            viol_n;
    logic             self_ref_q;
    cmd_e             cmd_q;
    viol_e            viol_q;
    logic [NBANK-1:0] open_v;
    logic [NBANK-1:0] pend_v;
    logic [CNT_W-1:0] mode_bl;
    logic             mode_full;
    logic             mode_ws;
    logic             sel_open;
    logic             any_open;
    logic             access;
    logic [CNT_W-1:0] ap_len;

    sdmon_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .self_ref(self_ref_q), .op(op)
    );

    assign sel_open = open_v[ba];
    assign any_open = |open_v;
    assign access   = (op == C_READ) || (op == C_WRITE);
    assign ap_len   = ((op == C_WRITE) && mode_ws) ? CNT_W'(1) : mode_bl;

    sdmon_mode u_mode (
        .clk(clk), .rst(rst),
        .load((op == C_LMODE) && !any_open),
        .bl_code_in(addr[2:0]),
        .wr_single_in(addr[WSINGLE_BIT]),
        .bl(mode_bl), .full_page(mode_full), .wr_single(mode_ws)
    );

    always_comb begin
        viol_n = V_NONE;
        case (op)
            C_ACT:          if (sel_open)  viol_n = V_ACT_OPEN;
            C_READ,C_WRITE: if (!sel_open) viol_n = V_IDLE_ACC;
            C_LMODE:        if (any_open)  viol_n = V_MODE_BUSY;
            C_AREF,C_SREF:  if (any_open)  viol_n = V_REF_BUSY;
            default:        viol_n = V_NONE;
        endcase
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));
        sdmon_bank #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst(rst),
            .act_hit((op == C_ACT) && hit && !open_v[i]),
            .close_hit((op == C_PRE) && (addr[AP_BIT] || hit)),
            .ap_start(access && hit && open_v[i] && addr[AP_BIT] && !mode_full),
            .ap_len(ap_len),
            .row_in(addr),
            .open_o(open_v[i]),
            .row_o(open_row_o[i*ROW_W +: ROW_W]),
            .pend_o(pend_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= C_INHIBIT;
            viol_q     <= V_NONE;
            self_ref_q <= 1'b0;
        end else begin
            cmd_q  <= op;
            viol_q <= viol_n;
            if (self_ref_q && cke)  self_ref_q <= 1'b0;
            else if (op == C_SREF)  self_ref_q <= 1'b1;
        end
    end

    assign cmd_o       = cmd_q;
    assign viol_code_o = viol_q;
    assign viol_o      = (viol_q != V_NONE);
    assign bank_open_o = open_v;
    assign ap_pend_o   = pend_v;
    assign self_ref_o  = self_ref_q;
endmodule

// File: rtl/sdmon_checker.sv
module sdmon_checker #(
    parameter int NBANK = 4,
    parameter int BA_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             cke,
    input logic             a10,
    input logic [BA_W-1:0]  ba,
    input logic [3:0]       cmd_o,
    input logic [2:0]       viol_code_o,
    input logic [NBANK-1:0] bank_open_o,
    input logic [NBANK-1:0] ap_pend_o,
    input logic             self_ref_o
);
    logic p_act, p_acc, p_pre, p_ref;
    assign p_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign p_acc = !cs_n &&  ras_n && !cas_n;
    assign p_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign p_ref = !cs_n && !ras_n && !cas_n &&  we_n;

    a_r1_inhibit: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cs_n) && !$past(self_ref_o)) |-> cmd_o == 4'd0);

    a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(p_act) && !$past(self_ref_o))
        |-> (bank_open_o & (NBANK'(1) << $past(ba))) != '0);

    a_r3_act_open_flag: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(p_act) && !$past(self_ref_o) && $past(bank_open_o[ba]))
        |-> viol_code_o == 3'd1);

    a_r4_idle_access: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(p_acc) && !$past(self_ref_o) && !$past(bank_open_o[ba]))
        |-> viol_code_o == 3'd2);

    a_r5_pend_needs_open: assert property (@(posedge clk) disable iff (rst)
        (ap_pend_o & ~bank_open_o) == '0);

    a_r8_pre_all: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(p_pre) && $past(a10) && !$past(self_ref_o))
        |-> bank_open_o == '0);

    a_r10_ref_busy: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(p_ref) && !$past(self_ref_o) && ($past(bank_open_o) != '0))
        |-> viol_code_o == 3'd4);

    a_r11_sr_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(self_ref_o) && !$past(cke))
        |-> (self_ref_o && cmd_o == 4'd0));
endmodule

bind sdram_bank_monitor sdmon_checker #(.NBANK(NBANK), .BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .a10(addr[AP_BIT]), .ba(ba),
    .cmd_o(cmd_o), .viol_code_o(viol_code_o), .bank_open_o(bank_open_o),
    .ap_pend_o(ap_pend_o), .self_ref_o(self_ref_o)
);

// File: tb/sim_sdram_bank_monitor.sv
`timescale 1ns/1ps
module sim_sdram_bank_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [3:0]  cmd_o;
    logic        viol_o;
    logic [2:0]  viol_code_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_row_o;
    logic [3:0]  ap_pend_o;
    logic        self_ref_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdram_bank_monitor u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .cmd_o(cmd_o),
        .viol_o(viol_o), .viol_code_o(viol_code_o), .bank_open_o(bank_open_o),
        .open_row_o(open_row_o), .ap_pend_o(ap_pend_o), .self_ref_o(self_ref_o)
    );

    typedef struct {
        logic [3:0]  cmd;
        logic [2:0]  viol;
        logic [3:0]  open;
        logic [3:0]  pend;
        logic        sr;
        int          rb;
        logic [12:0] row;
        string       tag;
    } exp_t;

    exp_t q[$];

    localparam int K_INH = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4,
                   K_BST = 5, K_PRE = 6, K_REF = 7, K_LMR = 8;

    task automatic issue(input int kind, input logic ck, input logic [12:0] a,
                         input logic [1:0] b, input logic [3:0] ecmd,
                         input logic [2:0] eviol, input logic [3:0] eopen,
                         input logic [3:0] epend, input logic esr, input int rb,
                         input logic [12:0] erow, input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = (kind == K_INH) ? 1'b1 : 1'b0;
        case (kind)
            K_INH: {ras_n, cas_n, we_n} = 3'b000;
            K_NOP: {ras_n, cas_n, we_n} = 3'b111;
            K_ACT: {ras_n, cas_n, we_n} = 3'b011;
            K_RD:  {ras_n, cas_n, we_n} = 3'b101;
            K_WR:  {ras_n, cas_n, we_n} = 3'b100;
            K_BST: {ras_n, cas_n, we_n} = 3'b110;
            K_PRE: {ras_n, cas_n, we_n} = 3'b010;
            K_REF: {ras_n, cas_n, we_n} = 3'b001;
            default: {ras_n, cas_n, we_n} = 3'b000;
        endcase
        cke = ck; addr = a; ba = b;
        e.cmd = ecmd; e.viol = eviol; e.open = eopen; e.pend = epend;
        e.sr = esr; e.rb = rb; e.row = erow; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic nop(input logic [3:0] eopen, input logic [3:0] epend, input string tag);
        issue(K_NOP, 1'b1, 13'h0, 2'd0, 4'd1, 3'd0, eopen, epend, 1'b0, -1, 13'h0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        logic [12:0] r;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && q.size() > 0) begin
                e = q.pop_front();
                r = (e.rb >= 0) ? open_row_o[e.rb*13 +: 13] : e.row;
                total++;
                if (cmd_o !== e.cmd || viol_code_o !== e.viol || viol_o !== (e.viol != 0) ||
                    bank_open_o !== e.open || ap_pend_o !== e.pend ||
                    self_ref_o !== e.sr || r !== e.row) begin
                    bad++;
                    $display("FAIL %s: act cmd=%0d viol=%0d open=%b pend=%b sr=%b row=%h exp cmd=%0d viol=%0d open=%b pend=%b sr=%b row=%h",
                             e.tag, cmd_o, viol_code_o, bank_open_o, ap_pend_o, self_ref_o, r,
                             e.cmd, e.viol, e.open, e.pend, e.sr, e.row);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (3000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (cmd_o !== 4'd0 || viol_o !== 1'b0 || viol_code_o !== 3'd0 || bank_open_o !== 4'd0 ||
            open_row_o !== '0 || ap_pend_o !== 4'd0 || self_ref_o !== 1'b0) begin
            bad++;
            $display("FAIL R12 reset: act cmd=%0d open=%b sr=%b exp all zero", cmd_o, bank_open_o, self_ref_o);
        end
        @(negedge clk); rst = 1'b0;

        nop(4'h0, 4'h0, "R1 nop");
        issue(K_INH, 1, 13'h0, 2'd0, 4'd0, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R1 inhibit");
        issue(K_LMR, 1, 13'h003, 2'd0, 4'd9, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R9 load idle");
        issue(K_ACT, 1, 13'h1ABC, 2'd0, 4'd2, 3'd0, 4'h1, 4'h0, 0, 0, 13'h1ABC, "R2 open b0");
        issue(K_ACT, 1, 13'h0055, 2'd2, 4'd2, 3'd0, 4'h5, 4'h0, 0, 2, 13'h0055, "R2 open b2");
        issue(K_ACT, 1, 13'h0111, 2'd0, 4'd2, 3'd1, 4'h5, 4'h0, 0, 0, 13'h1ABC, "R3 reopen b0");
        issue(K_RD,  1, 13'h0, 2'd1, 4'd3, 3'd2, 4'h5, 4'h0, 0, -1, 13'h0, "R4 read idle");
        issue(K_WR,  1, 13'h0, 2'd3, 4'd4, 3'd2, 4'h5, 4'h0, 0, -1, 13'h0, "R4 write idle");
        issue(K_LMR, 1, 13'h001, 2'd0, 4'd9, 3'd3, 4'h5, 4'h0, 0, -1, 13'h0, "R9 load busy");
        issue(K_REF, 1, 13'h0, 2'd0, 4'd7, 3'd4, 4'h5, 4'h0, 0, -1, 13'h0, "R10 aref busy");
        issue(K_RD,  1, 13'h400, 2'd0, 4'd3, 3'd0, 4'h5, 4'h1, 0, -1, 13'h0, "R5 ap read len8");
        for (int k = 0; k < 7; k++) nop(4'h5, 4'h1, "R5 burst in flight");
        nop(4'h4, 4'h0, "R9 R5 closed at n+8");
        issue(K_PRE, 1, 13'h0, 2'd2, 4'd6, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R8 single pre");
        issue(K_LMR, 1, 13'h201, 2'd0, 4'd9, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R7 load len2 wsingle");
        issue(K_ACT, 1, 13'h0005, 2'd1, 4'd2, 3'd0, 4'h2, 4'h0, 0, 1, 13'h0005, "R2 open b1");
        issue(K_WR,  1, 13'h400, 2'd1, 4'd4, 3'd0, 4'h2, 4'h2, 0, -1, 13'h0, "R7 ap write");
        nop(4'h0, 4'h0, "R7 write closed at n+1");
        issue(K_ACT, 1, 13'h0006, 2'd1, 4'd2, 3'd0, 4'h2, 4'h0, 0, 1, 13'h0006, "R2 reopen b1");
        issue(K_RD,  1, 13'h400, 2'd1, 4'd3, 3'd0, 4'h2, 4'h2, 0, -1, 13'h0, "R7 ap read len2");
        nop(4'h2, 4'h2, "R5 len2 in flight");
        nop(4'h0, 4'h0, "R5 len2 closed");
        issue(K_LMR, 1, 13'h007, 2'd0, 4'd9, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R6 load full page");
        issue(K_ACT, 1, 13'h0009, 2'd3, 4'd2, 3'd0, 4'h8, 4'h0, 0, 3, 13'h0009, "R2 open b3");
        issue(K_RD,  1, 13'h400, 2'd3, 4'd3, 3'd0, 4'h8, 4'h0, 0, -1, 13'h0, "R6 ap ignored");
        for (int k = 0; k < 3; k++) nop(4'h8, 4'h0, "R6 stays open");
        issue(K_ACT, 1, 13'h00AA, 2'd0, 4'd2, 3'd0, 4'h9, 4'h0, 0, 0, 13'h00AA, "R2 open b0 again");
        issue(K_PRE, 1, 13'h0, 2'd3, 4'd6, 3'd0, 4'h1, 4'h0, 0, -1, 13'h0, "R8 single pre b3");
        issue(K_ACT, 1, 13'h000C, 2'd3, 4'd2, 3'd0, 4'h9, 4'h0, 0, 3, 13'h000C, "R2 reopen b3");
        issue(K_PRE, 1, 13'h400, 2'd3, 4'd6, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R8 pre all");
        issue(K_BST, 1, 13'h0, 2'd0, 4'd5, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R1 burst stop");
        issue(K_REF, 0, 13'h0, 2'd0, 4'd8, 3'd0, 4'h0, 4'h0, 1, -1, 13'h0, "R11 enter sref");
        issue(K_ACT, 0, 13'h0033, 2'd0, 4'd0, 3'd0, 4'h0, 4'h0, 1, -1, 13'h0, "R11 act ignored");
        issue(K_NOP, 1, 13'h0, 2'd0, 4'd0, 3'd0, 4'h0, 4'h0, 0, -1, 13'h0, "R11 exit edge");
        issue(K_ACT, 1, 13'h0033, 2'd0, 4'd2, 3'd0, 4'h1, 4'h0, 0, 0, 13'h0033, "R11 act after exit");
        issue(K_REF, 0, 13'h0, 2'd0, 4'd8, 3'd4, 4'h1, 4'h0, 1, -1, 13'h0, "R10 sref busy");
        issue(K_NOP, 1, 13'h0, 2'd0, 4'd0, 3'd0, 4'h1, 4'h0, 0, -1, 13'h0, "R11 exit again");

        @(negedge clk);
        cs_n = 1'b1;
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule